// File: doc/BRIEF.md
# USB OTG Core Interrupt Status Register

This block holds the upper field of the core-level interrupt status word of a dual-role USB 2.0 controller. Five sticky event bits sit in positions 31 to 27. Hardware sets them from single-cycle event pulses, and software clears them by writing 1 to the register address. Position 26 is a live flag for the periodic transmit FIFO. Position 25 is a live aggregate of every host channel's pending interrupt.

The flag bits are read-only. The FIFO flag needs a selectable empty threshold and room in the periodic request queue. The channel aggregate falls only when the per-channel causes are cleared elsewhere. The session bit changes its source with the host/device role. A mask input selects which status bits drive one level-sensitive interrupt line.

All state lives in flip-flops. It resets synchronously on an active-high reset. The read word and the interrupt line come straight from registers.

Top module: `usb_core_irq_status`

## Requirements
- R1: While reset is held, the read word becomes 32'h0400_0000 (only bit 26 high) and the interrupt line is 0.
- R2: A disconnect pulse sets bit 29 and a connector-ID-change pulse sets bit 28, one clock after the pulse. Each bit then holds until it is cleared.
- R3: A write clears a sticky bit (31..27) only when the write address equals REG_ADDR and the matching write-data bit is 1. A write to another address, or a data bit of 0, leaves the bit unchanged.
- R4: When a set pulse and a write-1 clear reach the same sticky bit in the same cycle, the bit ends up 1.
- R5: The resume/remote-wakeup pulse sets bit 31 in both device mode (host_mode=0) and host mode (host_mode=1).
- R6: Bit 30 has a mode-dependent source. In device mode it is set by a low-to-high change of the b-valid input, and the session-request pulse is ignored. In host mode it is set by the session-request pulse, and b-valid changes are ignored.
- R7: The LPM pulse sets bit 27 only when the LPM enable input and the LPM-capable input are both 1. Otherwise bit 27 stays 0.
- R8: With the threshold select at 0 (half empty), bit 26 shows, one clock later, whether free words are at least PTX_DEPTH/2 and the request-queue space is nonzero.
- R9: With the threshold select at 1 (completely empty), bit 26 shows, one clock later, whether free words equal PTX_DEPTH and the request-queue space is nonzero.
- R10: Bit 25 shows, one clock later, the OR of the per-channel pending vector. Register writes change neither bit 25 nor bit 26.
- R11: Bits 24 to 0 of the read word are always 0.
- R12: The interrupt line equals, one clock later, the OR of the read word ANDed with the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_mode | input | 1 | 1 = host role, 0 = device role |
| resume_wake_pulse | input | 1 | Resume (device) or remote wakeup (host) detected |
| sess_req_pulse | input | 1 | Session request seen from attached device (host role) |
| bvalid_in | input | 1 | B-session valid level (device role) |
| disconnect_pulse | input | 1 | Device disconnect detected |
| conn_id_chg_pulse | input | 1 | Connector ID status changed |
| lpm_event_pulse | input | 1 | LPM transaction completed with a non-error response |
| lpm_enable | input | 1 | LPM feature enabled |
| lpm_capable | input | 1 | LPM-capable configuration bit |
| ptx_full_sel | input | 1 | Empty threshold: 0 half empty, 1 completely empty |
| ptx_free_words | input | $clog2(PTX_DEPTH+1) | Free words in the periodic transmit FIFO |
| preq_space | input | QSPACE_W | Free entries in the periodic request queue |
| chan_pending | input | NUM_CH | Per-channel interrupt pending vector |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 32 | Register write data |
| irq_mask | input | 32 | Per-bit interrupt enable |
| rd_data | output | 32 | Status read word |
| irq_out | output | 1 | Combined level interrupt |

## Verification
The bench builds the block with PTX_DEPTH=16 and NUM_CH=4. At these values the half threshold (8 free words) and the full threshold (16) are each a single input value, so both sides of each boundary can be driven exactly. Every channel position of the aggregate can also be covered in a few table rows. The remaining parameters keep their defaults, so the register address 0x014 is decoded against a nearby address 0x018.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

  localparam int STS_W       = 32;
  localparam int BIT_RESUME  = 31;
  localparam int BIT_SESS    = 30;
  localparam int BIT_DISC    = 29;
  localparam int BIT_CONID   = 28;
  localparam int BIT_LPM     = 27;
  localparam int BIT_PTXE    = 26;
  localparam int BIT_HCH     = 25;
  localparam int NUM_STICKY  = 5;
  localparam int STICKY_LSB  = BIT_LPM;
  localparam int LOW_ZERO_W  = BIT_HCH;

  // Field order matches bit order 31..27 so a cast lines the vector up.
  typedef struct packed {
    logic resume;
    logic sess;
    logic disc;
    logic conid;
    logic lpm;
  } sticky_ev_t;

endpackage

// File: rtl/usb_irq_sticky_bank.sv
module usb_irq_sticky_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);

  for (genvar gi = 0; gi < N; gi++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (rst)            bit_q <= 1'b0;
      else if (set_i[gi]) bit_q <= 1'b1;   // set has priority over clear
      else if (clr_i[gi]) bit_q <= 1'b0;
    end
    assign q_o[gi] = bit_q;
  end

endmodule

// File: rtl/usb_irq_event_src.sv
module usb_irq_event_src
  import usb_irq_pkg::*;
#(
  parameter bit LPM_PRESENT = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       host_mode,
  input  logic       resume_wake_pulse,
  input  logic       sess_req_pulse,
  input  logic       bvalid_in,
  input  logic       disconnect_pulse,
  input  logic       conn_id_chg_pulse,
  input  logic       lpm_event_pulse,
  input  logic       lpm_enable,
  input  logic       lpm_capable,
  output sticky_ev_t ev_o
);

  logic bvalid_q;
  logic bvalid_rise;

  // Track b-valid in every mode so a role switch never fakes an edge.
  always_ff @(posedge clk) begin
    if (rst) bvalid_q <= 1'b0;
    else     bvalid_q <= bvalid_in;
  end

  assign bvalid_rise = bvalid_in & ~bvalid_q;

  logic lpm_ev;
  if (LPM_PRESENT) begin : g_lpm
    assign lpm_ev = lpm_event_pulse & lpm_enable & lpm_capable;
  end else begin : g_no_lpm
    logic unused_lpm;
    assign unused_lpm = lpm_event_pulse ^ lpm_enable ^ lpm_capable;
    assign lpm_ev     = 1'b0;
  end

  always_comb begin
    ev_o.resume = resume_wake_pulse;
    ev_o.sess   = host_mode ? sess_req_pulse : bvalid_rise;
    ev_o.disc   = disconnect_pulse;
    ev_o.conid  = conn_id_chg_pulse;
    ev_o.lpm    = lpm_ev;
  end

endmodule

// File: rtl/usb_irq_ptx_flag.sv
module usb_irq_ptx_flag #(
  parameter int DEPTH    = 256,
  parameter int FREE_W   = $clog2(DEPTH + 1),
  parameter int QSPACE_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                full_sel,
  input  logic [FREE_W-1:0]   free_words,
  input  logic [QSPACE_W-1:0] queue_space,
  output logic                flag_o
);

  localparam logic [FREE_W-1:0] FULL_LVL = FREE_W'(DEPTH);
  localparam logic [FREE_W-1:0] HALF_LVL = FREE_W'(DEPTH / 2);

  logic level_met;
  logic queue_room;
  logic flag_q;

  assign level_met  = full_sel ? (free_words == FULL_LVL)
                               : (free_words >= HALF_LVL);
  assign queue_room = |queue_space;

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b1;
    else     flag_q <= level_met & queue_room;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/usb_irq_chan_agg.sv
module usb_irq_chan_agg #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] pending,
  output logic              any_o
);

  logic any_q;
  logic any_d;

  if (NUM_CH == 1) begin : g_single
    assign any_d = pending[0];
  end else begin : g_multi
    assign any_d = |pending;
  end

  always_ff @(posedge clk) begin
    if (rst) any_q <= 1'b0;
    else     any_q <= any_d;
  end

  assign any_o = any_q;

endmodule

// File: rtl/usb_core_irq_status.sv
module usb_core_irq_status
  import usb_irq_pkg::*;
#(
  parameter int              NUM_CH      = 16,
  parameter int              PTX_DEPTH   = 256,
  parameter int              QSPACE_W    = 4,
  parameter int              ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR  = 12'h014,
  parameter bit              LPM_PRESENT = 1'b1,
  parameter int              FREE_W      = $clog2(PTX_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                host_mode,
  input  logic                resume_wake_pulse,
  input  logic                sess_req_pulse,
  input  logic                bvalid_in,
  input  logic                disconnect_pulse,
  input  logic                conn_id_chg_pulse,
  input  logic                lpm_event_pulse,
  input  logic                lpm_enable,
  input  logic                lpm_capable,
  input  logic                ptx_full_sel,
  input  logic [FREE_W-1:0]   ptx_free_words,
  input  logic [QSPACE_W-1:0] preq_space,
  input  logic [NUM_CH-1:0]   chan_pending,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [STS_W-1:0]    wr_data,
  input  logic [STS_W-1:0]    irq_mask,
  output logic [STS_W-1:0]    rd_data,
  output logic                irq_out
);

  sticky_ev_t            ev;
  logic [NUM_STICKY-1:0] sticky_set;
  logic [NUM_STICKY-1:0] sticky_clr;
  logic [NUM_STICKY-1:0] sticky_q;
  logic                  ptx_flag;
  logic                  chan_any;
  logic                  wr_hit;
  logic [STS_W-1:0]      status;
  logic                  irq_q;

  usb_irq_event_src #(
    .LPM_PRESENT (LPM_PRESENT)
  ) u_event_src (
    .clk               (clk),
    .rst               (rst),
    .host_mode         (host_mode),
    .resume_wake_pulse (resume_wake_pulse),
    .sess_req_pulse    (sess_req_pulse),
    .bvalid_in         (bvalid_in),
    .disconnect_pulse  (disconnect_pulse),
    .conn_id_chg_pulse (conn_id_chg_pulse),
    .lpm_event_pulse   (lpm_event_pulse),
    .lpm_enable        (lpm_enable),
    .lpm_capable       (lpm_capable),
    .ev_o              (ev)
  );

  // Write-1-to-clear decode: only the sticky field of a matching write.
  assign wr_hit     = wr_en && (wr_addr == REG_ADDR);
  assign sticky_set = NUM_STICKY'(ev);
  assign sticky_clr = wr_hit ? wr_data[STS_W-1:STICKY_LSB] : '0;

  usb_irq_sticky_bank #(
    .N (NUM_STICKY)
  ) u_sticky (
    .clk   (clk),
    .rst   (rst),
    .set_i (sticky_set),
    .clr_i (sticky_clr),
    .q_o   (sticky_q)
  );

  usb_irq_ptx_flag #(
    .DEPTH    (PTX_DEPTH),
    .FREE_W   (FREE_W),
    .QSPACE_W (QSPACE_W)
  ) u_ptx_flag (
    .clk         (clk),
    .rst         (rst),
    .full_sel    (ptx_full_sel),
    .free_words  (ptx_free_words),
    .queue_space (preq_space),
    .flag_o      (ptx_flag)
  );

  usb_irq_chan_agg #(
    .NUM_CH (NUM_CH)
  ) u_chan_agg (
    .clk     (clk),
    .rst     (rst),
    .pending (chan_pending),
    .any_o   (chan_any)
  );

  assign status = {sticky_q, ptx_flag, chan_any, {LOW_ZERO_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(status & irq_mask);
  end

  assign rd_data = status;
  assign irq_out = irq_q;

endmodule

// File: rtl/usb_core_irq_status_chk.sv
module usb_core_irq_status_chk #(
  parameter int                ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'h014,
  parameter int                NUM_CH   = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              disconnect_pulse,
  input logic              lpm_event_pulse,
  input logic              lpm_enable,
  input logic              lpm_capable,
  input logic [NUM_CH-1:0] chan_pending,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic [31:0]       irq_mask,
  input logic [31:0]       rd_data,
  input logic              irq_out
);

  logic disc_clear;
  assign disc_clear = wr_en && (wr_addr == REG_ADDR) && wr_data[29];

  assert_reset_value_R1: assert property (@(posedge clk)
    rst |=> (rd_data == 32'h0400_0000 && !irq_out));

  assert_disc_set_R2: assert property (@(posedge clk) disable iff (rst)
    disconnect_pulse |=> rd_data[29]);

  assert_disc_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_data[29] && !disc_clear) |=> rd_data[29]);

  assert_disc_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (disc_clear && !disconnect_pulse) |=> !rd_data[29]);

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
    (disc_clear && disconnect_pulse) |=> rd_data[29]);

  assert_lpm_gate_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_data[27]) |-> $past(lpm_event_pulse && lpm_enable && lpm_capable));

  assert_chan_high_R10: assert property (@(posedge clk) disable iff (rst)
    (|chan_pending) |=> rd_data[25]);

  assert_chan_low_R10: assert property (@(posedge clk) disable iff (rst)
    !(|chan_pending) |=> !rd_data[25]);

  assert_low_zero_R11: assert property (@(posedge clk) disable iff (rst)
    rd_data[24:0] == 25'd0);

  assert_irq_on_R12: assert property (@(posedge clk) disable iff (rst)
    ((rd_data & irq_mask) != 32'd0) |=> irq_out);

  assert_irq_off_R12: assert property (@(posedge clk) disable iff (rst)
    ((rd_data & irq_mask) == 32'd0) |=> !irq_out);

endmodule

bind usb_core_irq_status usb_core_irq_status_chk #(
  .ADDR_W   (ADDR_W),
  .REG_ADDR (REG_ADDR),
  .NUM_CH   (NUM_CH)
) u_chk (
  .clk              (clk),
  .rst              (rst),
  .disconnect_pulse (disconnect_pulse),
  .lpm_event_pulse  (lpm_event_pulse),
  .lpm_enable       (lpm_enable),
  .lpm_capable      (lpm_capable),
  .chan_pending     (chan_pending),
  .wr_en            (wr_en),
  .wr_addr          (wr_addr),
  .wr_data          (wr_data),
  .irq_mask         (irq_mask),
  .rd_data          (rd_data),
  .irq_out          (irq_out)
);

// File: tb/usb_core_irq_status_bench.sv
`timescale 1ns/1ps
module usb_core_irq_status_bench;

  localparam int NUM_CH    = 4;
  localparam int PTX_DEPTH = 16;
  localparam int QSPACE_W  = 4;
  localparam int ADDR_W    = 12;
  localparam int FREE_W    = $clog2(PTX_DEPTH + 1);
  localparam logic [ADDR_W-1:0] REG_A = 12'h014;
  localparam logic [ADDR_W-1:0] BAD_A = 12'h018;

  // {full_sel, free[4:0], qspace[3:0], chan[3:0], exp26, exp25}
  localparam int NVEC = 8;
  localparam logic [15:0] VEC [NVEC] = '{
    {1'b0, 5'd8,  4'd1, 4'h0, 1'b1, 1'b0},
    {1'b0, 5'd7,  4'd1, 4'h1, 1'b0, 1'b1},
    {1'b0, 5'd16, 4'd0, 4'h0, 1'b0, 1'b0},
    {1'b1, 5'd15, 4'd3, 4'h8, 1'b0, 1'b1},
    {1'b1, 5'd16, 4'd1, 4'h0, 1'b1, 1'b0},
    {1'b0, 5'd12, 4'd2, 4'h4, 1'b1, 1'b1},
    {1'b1, 5'd8,  4'd1, 4'h2, 1'b0, 1'b1},
    {1'b0, 5'd0,  4'd1, 4'h0, 1'b0, 1'b0}
  };

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                host_mode = 1'b0;
  logic                resume_wake_pulse = 1'b0;
  logic                sess_req_pulse = 1'b0;
  logic                bvalid_in = 1'b0;
  logic                disconnect_pulse = 1'b0;
  logic                conn_id_chg_pulse = 1'b0;
  logic                lpm_event_pulse = 1'b0;
  logic                lpm_enable = 1'b0;
  logic                lpm_capable = 1'b0;
  logic                ptx_full_sel = 1'b0;
  logic [FREE_W-1:0]   ptx_free_words = 5'd16;
  logic [QSPACE_W-1:0] preq_space = 4'd1;
  logic [NUM_CH-1:0]   chan_pending = '0;
  logic                wr_en = 1'b0;
  logic [ADDR_W-1:0]   wr_addr = '0;
  logic [31:0]         wr_data = '0;
  logic [31:0]         irq_mask = '0;
  logic [31:0]         rd_data;
  logic                irq_out;

  int n_checks = 0;
  int n_errors = 0;

  always #2 clk = ~clk;

  usb_core_irq_status #(
    .NUM_CH    (NUM_CH),
    .PTX_DEPTH (PTX_DEPTH),
    .QSPACE_W  (QSPACE_W),
    .ADDR_W    (ADDR_W),
    .REG_ADDR  (REG_A)
  ) u_usb_core_irq_status (
    .clk (clk), .rst (rst), .host_mode (host_mode),
    .resume_wake_pulse (resume_wake_pulse), .sess_req_pulse (sess_req_pulse),
    .bvalid_in (bvalid_in), .disconnect_pulse (disconnect_pulse),
    .conn_id_chg_pulse (conn_id_chg_pulse), .lpm_event_pulse (lpm_event_pulse),
    .lpm_enable (lpm_enable), .lpm_capable (lpm_capable),
    .ptx_full_sel (ptx_full_sel), .ptx_free_words (ptx_free_words),
    .preq_space (preq_space), .chan_pending (chan_pending),
    .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
    .irq_mask (irq_mask), .rd_data (rd_data), .irq_out (irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_bits(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    #(4 * 100000);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick(); tick();
    chk("R1 reset word", rd_data, 32'h0400_0000);
    chk("R1 reset irq", {31'd0, irq_out}, 32'd0);
    rst = 1'b0;

    // Table walk: periodic FIFO flag and channel aggregate.
    for (int i = 0; i < NVEC; i++) begin
      ptx_full_sel   = VEC[i][15];
      ptx_free_words = VEC[i][14:10];
      preq_space     = VEC[i][9:6];
      chan_pending   = VEC[i][5:2];
      tick();
      chk(VEC[i][15] ? "R9 full-empty flag" : "R8 half-empty flag",
          {31'd0, rd_data[26]}, {31'd0, VEC[i][1]});
      chk("R10 channel aggregate", {31'd0, rd_data[25]}, {31'd0, VEC[i][0]});
    end
    ptx_full_sel = 1'b0; ptx_free_words = 5'd16; preq_space = 4'd1; chan_pending = '0;
    tick();

    // R2 set and hold
    disconnect_pulse = 1'b1; tick(); disconnect_pulse = 1'b0;
    chk("R2 disconnect set", {31'd0, rd_data[29]}, 32'd1);
    tick();
    chk("R2 disconnect hold", {31'd0, rd_data[29]}, 32'd1);
    conn_id_chg_pulse = 1'b1; tick(); conn_id_chg_pulse = 1'b0;
    chk("R2 conn-id set", {31'd0, rd_data[28]}, 32'd1);
    clear_bits(REG_A, 32'h1000_0000);

    // R3 address and data qualification
    clear_bits(BAD_A, 32'hFFFF_FFFF);
    chk("R3 wrong address", {31'd0, rd_data[29]}, 32'd1);
    clear_bits(REG_A, 32'h1000_0000);
    chk("R3 zero data bit", {31'd0, rd_data[29]}, 32'd1);
    clear_bits(REG_A, 32'h2000_0000);
    chk("R3 write-1 clear", {31'd0, rd_data[29]}, 32'd0);

    // R4 set beats clear
    conn_id_chg_pulse = 1'b1;
    clear_bits(REG_A, 32'h1000_0000);
    conn_id_chg_pulse = 1'b0;
    chk("R4 set wins", {31'd0, rd_data[28]}, 32'd1);
    clear_bits(REG_A, 32'h1000_0000);
    chk("R4 later clear", {31'd0, rd_data[28]}, 32'd0);

    // R5 resume / remote wakeup in both roles
    host_mode = 1'b0; resume_wake_pulse = 1'b1; tick(); resume_wake_pulse = 1'b0;
    chk("R5 device resume", {31'd0, rd_data[31]}, 32'd1);
    clear_bits(REG_A, 32'h8000_0000);
    chk("R5 cleared", {31'd0, rd_data[31]}, 32'd0);
    host_mode = 1'b1; resume_wake_pulse = 1'b1; tick(); resume_wake_pulse = 1'b0;
    chk("R5 host wakeup", {31'd0, rd_data[31]}, 32'd1);
    clear_bits(REG_A, 32'h8000_0000);

    // R6 session bit sources
    host_mode = 1'b0; bvalid_in = 1'b0; tick();
    sess_req_pulse = 1'b1; tick(); sess_req_pulse = 1'b0;
    chk("R6 device ignores session pulse", {31'd0, rd_data[30]}, 32'd0);
    bvalid_in = 1'b1; tick();
    chk("R6 b-valid rise", {31'd0, rd_data[30]}, 32'd1);
    clear_bits(REG_A, 32'h4000_0000);
    tick();
    chk("R6 steady b-valid no re-set", {31'd0, rd_data[30]}, 32'd0);
    host_mode = 1'b1; bvalid_in = 1'b0; tick(); bvalid_in = 1'b1; tick();
    chk("R6 host ignores b-valid", {31'd0, rd_data[30]}, 32'd0);
    sess_req_pulse = 1'b1; tick(); sess_req_pulse = 1'b0;
    chk("R6 host session request", {31'd0, rd_data[30]}, 32'd1);
    clear_bits(REG_A, 32'h4000_0000);
    host_mode = 1'b0;

    // R7 LPM gating
    lpm_enable = 1'b1; lpm_capable = 1'b0;
    lpm_event_pulse = 1'b1; tick(); lpm_event_pulse = 1'b0;
    chk("R7 not capable", {31'd0, rd_data[27]}, 32'd0);
    lpm_enable = 1'b0; lpm_capable = 1'b1;
    lpm_event_pulse = 1'b1; tick(); lpm_event_pulse = 1'b0;
    chk("R7 not enabled", {31'd0, rd_data[27]}, 32'd0);
    lpm_enable = 1'b1;
    lpm_event_pulse = 1'b1; tick(); lpm_event_pulse = 1'b0;
    chk("R7 both set", {31'd0, rd_data[27]}, 32'd1);
    clear_bits(REG_A, 32'h0800_0000);

    // R11 low field stays zero with everything raised
    disconnect_pulse = 1'b1; conn_id_chg_pulse = 1'b1; resume_wake_pulse = 1'b1;
    chan_pending = 4'hF;
    tick();
    disconnect_pulse = 1'b0; conn_id_chg_pulse = 1'b0; resume_wake_pulse = 1'b0;
    tick();
    chk("R11 low bits zero", {7'd0, rd_data[24:0]}, 32'd0);
    chk("R2 combined word", rd_data, 32'hB600_0000);

    // R10 writes do not touch read-only bits
    clear_bits(REG_A, 32'h0600_0000);
    chk("R10 write leaves flags", {30'd0, rd_data[26:25]}, 32'd3);
    chan_pending = '0; tick();
    chk("R10 aggregate falls", {31'd0, rd_data[25]}, 32'd0);

    // R12 masked interrupt line
    irq_mask = 32'h0000_0000; tick();
    chk("R12 fully masked", {31'd0, irq_out}, 32'd0);
    irq_mask = 32'h2000_0000; tick();
    chk("R12 enabled bit", {31'd0, irq_out}, 32'd1);
    clear_bits(REG_A, 32'h2000_0000);
    chk("R12 one-cycle lag", {31'd0, irq_out}, 32'd1);
    tick();
    chk("R12 drops after clear", {31'd0, irq_out}, 32'd0);
    irq_mask = 32'h0400_0000; tick();
    chk("R12 fifo flag irq", {31'd0, irq_out}, 32'd1);

    // R1 reset mid-run
    rst = 1'b1; tick();
    chk("R1 reset mid-run word", rd_data, 32'h0400_0000);
    chk("R1 reset mid-run irq", {31'd0, irq_out}, 32'd0);
    rst = 1'b0; irq_mask = '0;
    tick();

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule